// File: doc/BRIEF.md
# Receiver Lane Margining Controller

This block steers the margin measurement of one live receive lane. Software hands it one command at a time through a small command port. A step command names an axis and a direction, a step count, a dwell length in cycles and an error limit. The controller turns the command into a signed sampling-phase offset, for timing margin, or a signed slicer-threshold offset, for voltage margin. It drives that offset to the analog front end and counts the bit errors the lane reports while the offset is applied. At the end of the step it posts a one-cycle response that carries a status code and the error count.

The lane keeps carrying traffic for the whole measurement. The controller never holds the link or takes it down. When the link drops during a dwell, the controller backs off on its own. A clear command, an exceeded error limit and a link loss each bring the offsets back to nominal on the next clock edge. Voltage margining is optional and is selected by the `VOLT_EN` parameter. The step range is set separately for each axis.

Top module: `lane_margin_ctrl`

## Requirements
- R1: After reset both offsets are zero, `busy` is low and `rsp_valid` is low.
- R2: The timing axis uses direction codes 0 (left) and 1 (right). An accepted timing step drives `tim_ofs` to −steps for left or +steps for right after the accepting edge, sets `volt_ofs` to zero and raises `busy`. `tim_ofs` always stays within ±`MAX_TSTEP`.
- R3: The voltage axis uses direction codes 2 (up) and 3 (down). With `VOLT_EN`=1 an accepted voltage step drives `volt_ofs` to +steps for up or −steps for down, and sets `tim_ofs` to zero. With `VOLT_EN`=0 a voltage step is rejected with status 3 and neither offset changes.
- R4: Errors on `bit_err` are counted on the dwell-count edges that follow acceptance, with a dwell count of 0 treated as 1. The response is posted on the last of those edges with status 0 and the error count. The offset stays applied after the step ends.
- R5: When the running error count exceeds the error limit, the step stops at that edge. The response carries status 1 and a count of limit+1, and both offsets become zero.
- R6: A step count above the axis maximum (`MAX_TSTEP` or `MAX_VSTEP`) gives status 2 with a count of 0 in the next cycle, and neither offset changes.
- R7: A clear command (op code 2) is accepted in any state. It zeroes both offsets, drops `busy` and posts status 5 within one cycle. A clear takes priority over every other event.
- R8: A step command issued while `link_up` is low is rejected with status 4 and neither offset changes. If `link_up` falls during a dwell, the step ends at that edge with status 4 and both offsets become zero.
- R9: Step commands (op code 1) issued while `busy` is high are ignored and leave the offsets and the running step unchanged.
- R10: The error count saturates at its all-ones value. An error limit of all ones therefore never stops a step early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_up | input | 1 | Lane is in normal operation |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 1 = step, 2 = clear, other codes ignored |
| cmd_dir | input | 2 | 0 left, 1 right, 2 up, 3 down |
| cmd_steps | input | STEP_W | Step count |
| cmd_dwell | input | DWELL_W | Dwell length in cycles |
| cmd_limit | input | ERR_W | Error limit |
| bit_err | input | 1 | Bit error seen this cycle |
| tim_ofs | output | STEP_W+1 | Signed sampling-phase offset |
| volt_ofs | output | STEP_W+1 | Signed slicer-threshold offset |
| busy | output | 1 | Dwell in progress |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 3 | 0 ok, 1 limit, 2 bad step, 3 unsupported, 4 no link, 5 aborted |
| rsp_errs | output | ERR_W | Error count of the step |

## Verification
The assertions check on every cycle that a clear, a link loss or an exceeded limit always leaves both offsets at zero. They also check that at most one axis is offset at a time, that the timing offset stays in range, and that rejected or ignored step commands leave the offsets untouched. Exact dwell lengths, error counts, the handling of a zero dwell, the saturation of the count and the way the two axes replace each other depend on the stimulus, so only the bench's directed scenarios can show them.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  localparam logic [1:0] OP_STEP  = 2'd1;
  localparam logic [1:0] OP_CLEAR = 2'd2;

  localparam logic [1:0] DIR_LEFT  = 2'd0;
  localparam logic [1:0] DIR_RIGHT = 2'd1;
  localparam logic [1:0] DIR_UP    = 2'd2;
  localparam logic [1:0] DIR_DOWN  = 2'd3;

  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_LIMIT   = 3'd1;
  localparam logic [2:0] ST_BADSTEP = 3'd2;
  localparam logic [2:0] ST_UNSUPP  = 3'd3;
  localparam logic [2:0] ST_NOLINK  = 3'd4;
  localparam logic [2:0] ST_ABORT   = 3'd5;

  function automatic logic dir_is_vertical(input logic [1:0] d);
    return d[1];
  endfunction

  function automatic logic dir_is_negative(input logic [1:0] d);
    return (d == DIR_LEFT) || (d == DIR_DOWN);
  endfunction
endpackage

// File: rtl/lmc_cmd_check.sv
module lmc_cmd_check
  import lmc_pkg::*;
#(
  parameter int MAX_TSTEP = 15,
  parameter int MAX_VSTEP = 7,
  parameter int STEP_W    = 5,
  parameter bit VOLT_EN   = 1'b1,
  localparam int OFS_W    = STEP_W + 1
) (
  input  logic [1:0]              dir,
  input  logic [STEP_W-1:0]       steps,
  input  logic                    link_up,
  output logic                    ok,
  output logic [2:0]              rej_status,
  output logic                    vert,
  output logic signed [OFS_W-1:0] ofs_val
);
  localparam logic [STEP_W-1:0] TMAX = STEP_W'(MAX_TSTEP);
  localparam logic [STEP_W-1:0] VMAX = STEP_W'(MAX_VSTEP);

  function automatic logic signed [OFS_W-1:0] signed_ofs(
    input logic [1:0] d, input logic [STEP_W-1:0] s);
    logic signed [OFS_W-1:0] mag;
    mag = $signed({1'b0, s});
    return dir_is_negative(d) ? -mag : mag;
  endfunction

  function automatic logic step_in_range(
    input logic [1:0] d, input logic [STEP_W-1:0] s);
    return dir_is_vertical(d) ? (s <= VMAX) : (s <= TMAX);
  endfunction

  always_comb begin
    vert       = dir_is_vertical(dir);
    ofs_val    = signed_ofs(dir, steps);
    ok         = 1'b0;
    rej_status = ST_OK;
    if (!link_up)                    rej_status = ST_NOLINK;
    else if (vert && !VOLT_EN)       rej_status = ST_UNSUPP;
    else if (!step_in_range(dir, steps)) rej_status = ST_BADSTEP;
    else                             ok = 1'b1;
  end
endmodule

// File: rtl/lmc_dwell_ctr.sv
module lmc_dwell_ctr #(
  parameter int DWELL_W = 16,
  parameter int ERR_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic [DWELL_W-1:0] dwell_in,
  input  logic [ERR_W-1:0]   lim_in,
  input  logic               bit_err,
  output logic               active,
  output logic               ev_done,
  output logic               ev_over,
  output logic [ERR_W-1:0]   errs_n,
  output logic [ERR_W-1:0]   lim_q
);
  localparam logic [ERR_W-1:0]   ERR_MAX   = '1;
  localparam logic [DWELL_W-1:0] DWELL_ONE = DWELL_W'(1);

  logic [DWELL_W-1:0] cnt_q;
  logic [ERR_W-1:0]   errs_q;

  function automatic logic [ERR_W-1:0] sat_inc(
    input logic [ERR_W-1:0] v, input logic inc);
    return (inc && v != ERR_MAX) ? v + ERR_W'(1) : v;
  endfunction

  always_comb begin
    errs_n  = sat_inc(errs_q, bit_err);
    ev_over = active && !stop && (errs_n > lim_q);
    ev_done = active && !stop && !ev_over && (cnt_q == DWELL_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      errs_q <= '0;
      lim_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= (dwell_in == '0) ? DWELL_ONE : dwell_in;
      errs_q <= '0;
      lim_q  <= lim_in;
    end else if (active) begin
      if (stop || ev_over || ev_done) begin
        active <= 1'b0;
      end else begin
        cnt_q  <= cnt_q - DWELL_ONE;
        errs_q <= errs_n;
      end
    end
  end
endmodule

// File: rtl/lmc_offset_reg.sv
module lmc_offset_reg #(
  parameter int  OFS_W   = 6,
  parameter bit  VOLT_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    load_vert,
  input  logic signed [OFS_W-1:0] load_val,
  input  logic                    zero,
  output logic signed [OFS_W-1:0] tim_ofs,
  output logic signed [OFS_W-1:0] volt_ofs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tim_ofs <= '0;
    else if (zero)   tim_ofs <= '0;
    else if (load)   tim_ofs <= load_vert ? '0 : load_val;
  end

  generate
    if (VOLT_EN) begin : g_volt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    volt_ofs <= '0;
        else if (zero) volt_ofs <= '0;
        else if (load) volt_ofs <= load_vert ? load_val : '0;
      end
    end else begin : g_novolt
      assign volt_ofs = '0;
    end
  endgenerate
endmodule

// File: rtl/lane_margin_ctrl.sv
module lane_margin_ctrl
  import lmc_pkg::*;
#(
  parameter int MAX_TSTEP = 15,
  parameter int MAX_VSTEP = 7,
  parameter bit VOLT_EN   = 1'b1,
  parameter int DWELL_W   = 16,
  parameter int ERR_W     = 6,
  parameter int STEP_W    = $clog2(((MAX_TSTEP > MAX_VSTEP) ? MAX_TSTEP : MAX_VSTEP) + 1) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      link_up,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [1:0]                cmd_dir,
  input  logic [STEP_W-1:0]         cmd_steps,
  input  logic [DWELL_W-1:0]        cmd_dwell,
  input  logic [ERR_W-1:0]          cmd_limit,
  input  logic                      bit_err,
  output logic signed [STEP_W:0]    tim_ofs,
  output logic signed [STEP_W:0]    volt_ofs,
  output logic                      busy,
  output logic                      rsp_valid,
  output logic [2:0]                rsp_status,
  output logic [ERR_W-1:0]          rsp_errs
);
  localparam int OFS_W = STEP_W + 1;

  logic                    chk_ok, chk_vert;
  logic [2:0]              chk_status;
  logic signed [OFS_W-1:0] chk_ofs;
  logic                    ev_done, ev_over;
  logic [ERR_W-1:0]        errs_n, lim_q;

  // named events shared with the checker
  logic clr_cmd, step_cmd, step_accept, step_reject, link_lost, stop_dwell, zero_ofs;

  always_comb begin
    clr_cmd     = cmd_valid && (cmd_op == OP_CLEAR);
    step_cmd    = cmd_valid && (cmd_op == OP_STEP) && !busy && !clr_cmd;
    step_accept = step_cmd && chk_ok;
    step_reject = step_cmd && !chk_ok;
    link_lost   = busy && !link_up && !clr_cmd;
    stop_dwell  = clr_cmd || link_lost;
    zero_ofs    = clr_cmd || link_lost || ev_over;
  end

  lmc_cmd_check #(
    .MAX_TSTEP(MAX_TSTEP), .MAX_VSTEP(MAX_VSTEP),
    .STEP_W(STEP_W), .VOLT_EN(VOLT_EN)
  ) u_check (
    .dir(cmd_dir), .steps(cmd_steps), .link_up(link_up),
    .ok(chk_ok), .rej_status(chk_status), .vert(chk_vert), .ofs_val(chk_ofs)
  );

  lmc_dwell_ctr #(.DWELL_W(DWELL_W), .ERR_W(ERR_W)) u_dwell (
    .clk(clk), .rst_n(rst_n), .start(step_accept), .stop(stop_dwell),
    .dwell_in(cmd_dwell), .lim_in(cmd_limit), .bit_err(bit_err),
    .active(busy), .ev_done(ev_done), .ev_over(ev_over),
    .errs_n(errs_n), .lim_q(lim_q)
  );

  lmc_offset_reg #(.OFS_W(OFS_W), .VOLT_EN(VOLT_EN)) u_ofs (
    .clk(clk), .rst_n(rst_n), .load(step_accept), .load_vert(chk_vert),
    .load_val(chk_ofs), .zero(zero_ofs),
    .tim_ofs(tim_ofs), .volt_ofs(volt_ofs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_errs   <= '0;
    end else begin
      rsp_valid <= 1'b1;
      if (clr_cmd) begin
        rsp_status <= ST_ABORT;   rsp_errs <= '0;
      end else if (link_lost) begin
        rsp_status <= ST_NOLINK;  rsp_errs <= errs_n;
      end else if (ev_over) begin
        rsp_status <= ST_LIMIT;   rsp_errs <= errs_n;
      end else if (ev_done) begin
        rsp_status <= ST_OK;      rsp_errs <= errs_n;
      end else if (step_reject) begin
        rsp_status <= chk_status; rsp_errs <= '0;
      end else begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker
  import lmc_pkg::*;
#(
  parameter int MAX_TSTEP = 15,
  parameter int STEP_W    = 5,
  parameter int ERR_W     = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    link_up,
  input logic                    cmd_valid,
  input logic [1:0]              cmd_op,
  input logic [1:0]              cmd_dir,
  input logic [STEP_W-1:0]       cmd_steps,
  input logic                    busy,
  input logic signed [STEP_W:0]  tim_ofs,
  input logic signed [STEP_W:0]  volt_ofs,
  input logic                    rsp_valid,
  input logic [2:0]              rsp_status,
  input logic [ERR_W-1:0]        rsp_errs,
  input logic                    ev_over,
  input logic [ERR_W-1:0]        lim_q
);
  localparam logic [STEP_W-1:0]   TMAX  = STEP_W'(MAX_TSTEP);
  localparam logic signed [STEP_W:0] TPOS = (STEP_W+1)'(MAX_TSTEP);

  AST_CLEAR_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_CLEAR) |=> (tim_ofs == 0 && volt_ofs == 0 && !busy && rsp_status == ST_ABORT)); // R7

  AST_BADSTEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_STEP && !busy && link_up && !cmd_dir[1] && cmd_steps > TMAX)
    |=> ($stable(tim_ofs) && $stable(volt_ofs) && rsp_valid && rsp_status == ST_BADSTEP)); // R6

  AST_LIMIT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_LIMIT) |-> (tim_ofs == 0 && volt_ofs == 0)); // R5

  AST_OK_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_OK) |-> (rsp_errs <= lim_q)); // R4

  AST_ONE_AXIS: assert property (@(posedge clk) disable iff (!rst_n)
    !(tim_ofs != 0 && volt_ofs != 0)); // R2

  AST_TIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tim_ofs <= TPOS && tim_ofs >= -TPOS)); // R2

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cmd_op == OP_STEP && link_up && !ev_over)
    |=> ($stable(tim_ofs) && $stable(volt_ofs))); // R9

  AST_LINK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !link_up && !(cmd_valid && cmd_op == OP_CLEAR))
    |=> (!busy && tim_ofs == 0 && volt_ofs == 0 && rsp_status == ST_NOLINK)); // R8

  AST_NOLINK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !link_up && cmd_valid && cmd_op == OP_STEP)
    |=> ($stable(tim_ofs) && $stable(volt_ofs) && rsp_status == ST_NOLINK)); // R8
endmodule

bind lane_margin_ctrl lmc_checker #(
  .MAX_TSTEP(MAX_TSTEP), .STEP_W(STEP_W), .ERR_W(ERR_W)
) u_lmc_checker (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_dir(cmd_dir), .cmd_steps(cmd_steps), .busy(busy),
  .tim_ofs(tim_ofs), .volt_ofs(volt_ofs), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .rsp_errs(rsp_errs), .ev_over(ev_over), .lim_q(lim_q)
);

// File: tb/test_lane_margin_ctrl.sv
module test_lane_margin_ctrl;
  localparam int STEP_W = 5;
  localparam int ERR_W  = 6;
  localparam int DWELL_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, link_up = 1'b1;
  logic cmd_valid = 1'b0, bit_err = 1'b0;
  logic [1:0] cmd_op = '0, cmd_dir = '0;
  logic [STEP_W-1:0] cmd_steps = '0;
  logic [DWELL_W-1:0] cmd_dwell = '0;
  logic [ERR_W-1:0] cmd_limit = '0;
  logic signed [STEP_W:0] tim_ofs, volt_ofs;
  logic busy, rsp_valid;
  logic [2:0] rsp_status;
  logic [ERR_W-1:0] rsp_errs;

  int n_checks = 0, n_errors = 0;

  always #2.5 clk = ~clk;

  lane_margin_ctrl i_lane_margin_ctrl (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_dir(cmd_dir), .cmd_steps(cmd_steps),
    .cmd_dwell(cmd_dwell), .cmd_limit(cmd_limit), .bit_err(bit_err),
    .tim_ofs(tim_ofs), .volt_ofs(volt_ofs), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_errs(rsp_errs)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // drive one command for one cycle, return at the negedge after the accepting edge
  task automatic issue(input logic [1:0] op, input logic [1:0] dir, input int steps,
                       input int dwell, input int limit);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_dir = dir;
    cmd_steps = STEP_W'(steps); cmd_dwell = DWELL_W'(dwell); cmd_limit = ERR_W'(limit);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // full step: errors on the first nerr dwell cycles
  task automatic run_step(input string req, input logic [1:0] dir, input int steps,
                          input int dwell, input int limit, input int nerr,
                          input int exp_tim, input int exp_volt);
    int cycles, exp_cycles, exp_errs, exp_st, eff;
    issue(2'd1, dir, steps, dwell, limit);
    chk_eq(req, "applied tim_ofs", int'(tim_ofs), exp_tim);
    chk_eq(req, "applied volt_ofs", int'(volt_ofs), exp_volt);
    chk_eq(req, "busy after accept", int'(busy), 1);
    cycles = 0;
    while (cycles < 300) begin
      bit_err = (cycles < nerr);
      @(negedge clk);
      cycles++;
      if (rsp_valid) break;
    end
    bit_err = 1'b0;
    exp_cycles = (dwell == 0) ? 1 : dwell;
    eff = (nerr < exp_cycles) ? nerr : exp_cycles;
    if (eff > 63) eff = 63;
    if (nerr > limit && limit < 63) begin
      exp_cycles = limit + 1; exp_errs = limit + 1; exp_st = 1;
      exp_tim = 0; exp_volt = 0;
    end else begin
      exp_errs = eff; exp_st = 0;
    end
    chk_eq(req, "dwell cycles", cycles, exp_cycles);
    chk_eq(req, "status", int'(rsp_status), exp_st);
    chk_eq(req, "error count", int'(rsp_errs), exp_errs);
    chk_eq(req, "final tim_ofs", int'(tim_ofs), exp_tim);
    chk_eq(req, "final volt_ofs", int'(volt_ofs), exp_volt);
    chk_eq(req, "busy after end", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk_eq("R1", "reset tim_ofs", int'(tim_ofs), 0);
    chk_eq("R1", "reset volt_ofs", int'(volt_ofs), 0);
    chk_eq("R1", "reset busy", int'(busy), 0);
    chk_eq("R1", "reset rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_timing();
    run_step("R2", 2'd1, 5, 8, 4, 2, 5, 0);
    run_step("R2", 2'd0, 15, 6, 4, 0, -15, 0);
    run_step("R4", 2'd1, 1, 0, 4, 1, 1, 0);
  endtask

  task automatic t_voltage();
    run_step("R3", 2'd2, 7, 3, 2, 1, 0, 7);
    run_step("R3", 2'd3, 3, 4, 2, 0, 0, -3);
  endtask

  task automatic t_badstep();
    // offsets are at volt -3 from the previous scenario
    issue(2'd1, 2'd1, 16, 5, 3);
    chk_eq("R6", "bad timing rsp_valid", int'(rsp_valid), 1);
    chk_eq("R6", "bad timing status", int'(rsp_status), 2);
    chk_eq("R6", "bad timing volt held", int'(volt_ofs), -3);
    chk_eq("R6", "bad timing tim held", int'(tim_ofs), 0);
    issue(2'd1, 2'd2, 8, 5, 3);
    chk_eq("R6", "bad voltage status", int'(rsp_status), 2);
    chk_eq("R6", "bad voltage volt held", int'(volt_ofs), -3);
    chk_eq("R6", "bad voltage busy", int'(busy), 0);
  endtask

  task automatic t_limit();
    run_step("R5", 2'd0, 4, 20, 2, 10, -4, 0);
  endtask

  task automatic t_clear();
    issue(2'd1, 2'd1, 9, 50, 10);
    repeat (4) @(negedge clk);
    chk_eq("R7", "offset before clear", int'(tim_ofs), 9);
    issue(2'd2, 2'd0, 0, 0, 0);
    chk_eq("R7", "clear tim_ofs", int'(tim_ofs), 0);
    chk_eq("R7", "clear busy", int'(busy), 0);
    chk_eq("R7", "clear rsp_valid", int'(rsp_valid), 1);
    chk_eq("R7", "clear status", int'(rsp_status), 5);
  endtask

  task automatic t_link();
    link_up = 1'b0;
    issue(2'd1, 2'd1, 3, 5, 3);
    chk_eq("R8", "no-link status", int'(rsp_status), 4);
    chk_eq("R8", "no-link tim held", int'(tim_ofs), 0);
    chk_eq("R8", "no-link busy", int'(busy), 0);
    link_up = 1'b1;
    issue(2'd1, 2'd0, 6, 40, 10);
    repeat (3) @(negedge clk);
    link_up = 1'b0;
    @(negedge clk);
    chk_eq("R8", "loss rsp_valid", int'(rsp_valid), 1);
    chk_eq("R8", "loss status", int'(rsp_status), 4);
    chk_eq("R8", "loss tim_ofs", int'(tim_ofs), 0);
    chk_eq("R8", "loss busy", int'(busy), 0);
    link_up = 1'b1;
  endtask

  task automatic t_busy_ignore();
    int cycles;
    issue(2'd1, 2'd1, 3, 10, 5);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_dir = 2'd2; cmd_steps = 5'd5;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk_eq("R9", "ignored tim_ofs", int'(tim_ofs), 3);
    chk_eq("R9", "ignored volt_ofs", int'(volt_ofs), 0);
    chk_eq("R9", "ignored busy", int'(busy), 1);
    cycles = 2;
    while (cycles < 100 && !rsp_valid) begin
      @(negedge clk);
      cycles++;
    end
    chk_eq("R9", "step length unchanged", cycles, 10);
    chk_eq("R9", "step status", int'(rsp_status), 0);
  endtask

  task automatic t_saturate();
    run_step("R10", 2'd1, 2, 70, 63, 70, 2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_timing();
    t_voltage();
    t_badstep();
    t_limit();
    t_clear();
    t_link();
    t_busy_ignore();
    t_saturate();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule